// File: doc/BRIEF.md
# Up-Counting Period Timer

This block is a 16-bit timer that counts upward on a qualified tick and restarts from zero after it reaches a programmable period value. A full cycle therefore spans the period value plus one counts. Ticks come in as a single-cycle enable on `tick_i`, synchronous to `clk`. A prescaler built as a clock enable can slow the count by 1, 2, 4 or 8. No derived clock is used.

Software reaches the block through a small register port with separate write and read addresses. The control register holds a run-mode field, the prescaler select, a self-clearing clear bit, two interrupt enables and the two sticky event flags. The count register can be read and written directly. The period register sets the restart value. There are two flags. The compare flag marks the tick on which the count lands on the period value. The wrap flag marks the tick on which the count returns from the period value to zero. `irq_o` is asserted while either flag is set and its enable is on.

Top module: `tmr_upcount`

## Requirements
- R1: After a synchronous reset, the count, period and control registers read zero, and both flags and `irq_o` are low.
- R2: On each enabled tick with a nonzero run-mode field (control bits 1:0), the count increments while below the period value. From the period value it goes to zero, so one cycle is period+1 counts.
- R3: If an enabled tick finds the count above the period value, the count goes to zero on that tick and the wrap flag is not set.
- R4: The compare flag (control bit 8) is set by any tick whose new count equals the period value. This includes a period of zero.
- R5: The wrap flag (control bit 9) is set by a tick that moves the count from the period value to zero.
- R6: The prescaler select (control bits 3:2) gives one count per 1, 2, 4 or 8 ticks for the values 0, 1, 2 and 3.
- R7: A run-mode field of zero holds the count and the prescaler state however many ticks arrive.
- R8: Writing 1 to the clear bit (control bit 4) zeroes the count and the prescaler phase in that same cycle. The clear bit always reads back 0.
- R9: Flags stay set until a control write puts 0 in their bit. Writing 1 to a flag bit leaves it unchanged. An event in the same cycle as a clearing write leaves the flag set.
- R10: `irq_o` equals (compare flag AND compare enable, bit 5) OR (wrap flag AND wrap enable, bit 6), and it changes in the same cycle as the flags.
- R11: The register addresses are control at 0, count at 1, period at 2, and address 3 reads zero. `rd_data_o` shows the addressed register one cycle after `rd_addr_i` is set. A count write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timer tick enable, one per source clock edge |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 16 | Registered read data |
| count_o | output | 16 | Present count value |
| cmp_flag_o | output | 1 | Compare flag |
| wrap_flag_o | output | 1 | Wrap flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Several rules are checked on every cycle:
- a rising wrap flag coincides with a zero count;
- a rising compare flag coincides with the count equal to the period;
- any unforced count change is either +1 or a return to zero;
- a stopped mode freezes the count;
- a clear forces zero;
- the interrupt output tracks the enabled flags.

Exact cycle counts cannot be judged cycle by cycle and only the bench scenarios show them. These cover period lengths, the restart from above the period, the prescaler ratios, the prescaler phase reset by clear, the write-zero flag semantics and the race between an event and a clearing write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_PERIOD = 2'd2;

  localparam int BIT_MODE_LO = 0;
  localparam int BIT_PS_LO   = 2;
  localparam int BIT_CLR     = 4;
  localparam int BIT_CMP_EN  = 5;
  localparam int BIT_WRAP_EN = 6;
  localparam int BIT_CMP_FLG = 8;
  localparam int BIT_WRAP_FLG = 9;

  typedef struct packed {
    logic [1:0] run_mode;
    logic [1:0] ps_sel;
    logic       cmp_en;
    logic       wrap_en;
  } tmr_ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 2,
  localparam int DIV_W = (1 << PS_W) - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_i,
  input  logic            run_i,
  input  logic            clr_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            step_o
);

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] limit;
  logic             adv;

  assign limit  = ~({DIV_W{1'b1}} << sel_i);
  assign adv    = tick_i && run_i && !clr_i;
  assign step_o = adv && (phase_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      phase_q <= '0;
    end else if (adv) begin
      if (phase_q >= limit) phase_q <= '0;
      else                  phase_q <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             cmp_evt_o,
  output logic             wrap_evt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic             at_or_above;
  logic             live;

  assign at_or_above = (cnt_q >= period_i);
  assign cnt_next    = at_or_above ? '0 : cnt_q + 1'b1;
  assign live        = step_i && !clr_i && !load_i;
  assign cmp_evt_o   = live && (cnt_next == period_i);
  assign wrap_evt_o  = live && (cnt_q == period_i);
  assign count_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)   cnt_q <= '0;
    else if (load_i)    cnt_q <= load_val_i;
    else if (step_i)    cnt_q <= cnt_next;
  end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int               CNT_W      = 16,
  parameter logic [CNT_W-1:0] PERIOD_RST = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             cmp_evt_i,
  input  logic             wrap_evt_i,
  output tmr_ctrl_t        ctrl_o,
  output logic [CNT_W-1:0] period_o,
  output logic             clr_o,
  output logic             load_o,
  output logic             per_wr_o,
  output logic             cmp_flag_o,
  output logic             wrap_flag_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] rd_data_o
);

  tmr_ctrl_t        ctrl_q, ctrl_n;
  logic [CNT_W-1:0] period_q;
  logic             cmp_q, wrap_q, cmp_n, wrap_n, irq_q;
  logic [CNT_W-1:0] rd_q, rd_n;
  logic             ctrl_wr;

  assign ctrl_wr  = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign load_o   = wr_en_i && (wr_addr_i == ADDR_COUNT);
  assign per_wr_o = wr_en_i && (wr_addr_i == ADDR_PERIOD);
  assign clr_o    = ctrl_wr && wr_data_i[BIT_CLR];

  always_comb begin
    ctrl_n = ctrl_q;
    if (ctrl_wr) begin
      ctrl_n.run_mode = wr_data_i[BIT_MODE_LO +: 2];
      ctrl_n.ps_sel   = wr_data_i[BIT_PS_LO +: 2];
      ctrl_n.cmp_en   = wr_data_i[BIT_CMP_EN];
      ctrl_n.wrap_en  = wr_data_i[BIT_WRAP_EN];
    end
    cmp_n  = cmp_evt_i  || (cmp_q  && !(ctrl_wr && !wr_data_i[BIT_CMP_FLG]));
    wrap_n = wrap_evt_i || (wrap_q && !(ctrl_wr && !wr_data_i[BIT_WRAP_FLG]));
  end

  always_comb begin
    rd_n = '0;
    case (rd_addr_i)
      ADDR_CTRL: begin
        rd_n[BIT_MODE_LO +: 2] = ctrl_q.run_mode;
        rd_n[BIT_PS_LO +: 2]   = ctrl_q.ps_sel;
        rd_n[BIT_CMP_EN]       = ctrl_q.cmp_en;
        rd_n[BIT_WRAP_EN]      = ctrl_q.wrap_en;
        rd_n[BIT_CMP_FLG]      = cmp_q;
        rd_n[BIT_WRAP_FLG]     = wrap_q;
      end
      ADDR_COUNT:  rd_n = count_i;
      ADDR_PERIOD: rd_n = period_q;
      default:     rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= PERIOD_RST;
      cmp_q    <= 1'b0;
      wrap_q   <= 1'b0;
      irq_q    <= 1'b0;
      rd_q     <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      if (per_wr_o) period_q <= wr_data_i;
      cmp_q  <= cmp_n;
      wrap_q <= wrap_n;
      irq_q  <= (cmp_n && ctrl_n.cmp_en) || (wrap_n && ctrl_n.wrap_en);
      rd_q   <= rd_n;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign period_o    = period_q;
  assign cmp_flag_o  = cmp_q;
  assign wrap_flag_o = wrap_q;
  assign irq_o       = irq_q;
  assign rd_data_o   = rd_q;

endmodule

// File: rtl/tmr_upcount.sv
module tmr_upcount
  import tmr_pkg::*;
#(
  parameter int               CNT_W      = 16,
  parameter int               PS_W       = 2,
  parameter logic [CNT_W-1:0] PERIOD_RST = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             cmp_flag_o,
  output logic             wrap_flag_o,
  output logic             irq_o
);

  tmr_ctrl_t        ctrl;
  logic [CNT_W-1:0] period;
  logic             clr, load, per_wr, step, run;
  logic             cmp_evt, wrap_evt;

  assign run = (ctrl.run_mode != 2'd0);

  tmr_regs #(.CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .count_i(count_o),
    .cmp_evt_i(cmp_evt), .wrap_evt_i(wrap_evt),
    .ctrl_o(ctrl), .period_o(period), .clr_o(clr), .load_o(load),
    .per_wr_o(per_wr), .cmp_flag_o(cmp_flag_o), .wrap_flag_o(wrap_flag_o),
    .irq_o(irq_o), .rd_data_o(rd_data_o)
  );

  tmr_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(run), .clr_i(clr),
    .sel_i(ctrl.ps_sel), .step_o(step)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step_i(step), .clr_i(clr), .load_i(load),
    .load_val_i(wr_data_i), .period_i(period), .count_o(count_o),
    .cmp_evt_o(cmp_evt), .wrap_evt_o(wrap_evt)
  );

endmodule

// File: rtl/tmr_upcount_chk.sv
module tmr_upcount_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] period,
  input logic             cmp_flag_o,
  input logic             wrap_flag_o,
  input logic             irq_o,
  input logic             load,
  input logic             clr,
  input logic             per_wr,
  input logic             run,
  input logic             cmp_en,
  input logic             wrap_en
);

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wrap_flag_o) |-> (count_o == '0));

  assert_cmp_match_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(cmp_flag_o) && !$past(per_wr)) |-> (count_o == period));

  assert_step_shape_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && !$stable(count_o)) |->
      ((count_o == $past(count_o) + 1'b1) || (count_o == '0)));

  assert_stop_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(run) && !$past(load) && !$past(clr)) |-> $stable(count_o));

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (count_o == '0));

  assert_irq_track_R10: assert property (@(posedge clk) disable iff (rst)
    irq_o == ((cmp_flag_o && cmp_en) || (wrap_flag_o && wrap_en)));

endmodule

bind tmr_upcount tmr_upcount_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .count_o(count_o), .period(period),
  .cmp_flag_o(cmp_flag_o), .wrap_flag_o(wrap_flag_o), .irq_o(irq_o),
  .load(load), .clr(clr), .per_wr(per_wr), .run(run),
  .cmp_en(ctrl.cmp_en), .wrap_en(ctrl.wrap_en)
);

// File: tb/tmr_upcount_bench.sv
`timescale 1ns/1ps
module tmr_upcount_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o, count_o;
  logic        cmp_flag_o, wrap_flag_o, irq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tmr_upcount u_tmr_upcount (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .count_o(count_o), .cmp_flag_o(cmp_flag_o),
    .wrap_flag_o(wrap_flag_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] start;
    logic [4:0]  ticks;
    logic [15:0] exp_cnt;
    logic        exp_cmp;
    logic        exp_wrap;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'd10,    16'd0,    5'd5,  16'd5,    1'b0, 1'b0},
    '{16'd10,    16'd0,    5'd10, 16'd10,   1'b1, 1'b0},
    '{16'd10,    16'd0,    5'd11, 16'd0,    1'b1, 1'b1},
    '{16'd10,    16'd8,    5'd1,  16'd9,    1'b0, 1'b0},
    '{16'd10,    16'd9,    5'd1,  16'd10,   1'b1, 1'b0},
    '{16'd10,    16'd10,   5'd1,  16'd0,    1'b0, 1'b1},
    '{16'd5,     16'd20,   5'd1,  16'd0,    1'b0, 1'b0},
    '{16'd5,     16'd20,   5'd6,  16'd5,    1'b1, 1'b0},
    '{16'd0,     16'd0,    5'd3,  16'd0,    1'b1, 1'b1},
    '{16'hFFFF,  16'hFFFE, 5'd1,  16'hFFFF, 1'b1, 1'b0},
    '{16'hFFFF,  16'hFFFF, 5'd1,  16'd0,    1'b0, 1'b1},
    '{16'd3,     16'd0,    5'd8,  16'd0,    1'b1, 1'b1}
  };

  function automatic logic [15:0] cw(input logic [1:0] mode, input logic [1:0] ps,
                                     input logic clr, input logic cen, input logic wen,
                                     input logic kc, input logic kw);
    logic [15:0] w;
    w = '0;
    w[1:0] = mode; w[3:2] = ps; w[4] = clr; w[5] = cen; w[6] = wen;
    w[8] = kc; w[9] = kw;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr_i = a;
    @(negedge clk);
    v = rd_data_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 flags", {cmp_flag_o, wrap_flag_o, irq_o}, 0);
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd2, v); chk("R1 period", v, 0);

    // R2 R3 R4 R5 table walk
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, cw(2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
      wr(2'd2, VECS[i].per);
      wr(2'd1, VECS[i].start);
      ticks(int'(VECS[i].ticks));
      chk($sformatf("R2 R3 count vec%0d", i), count_o, VECS[i].exp_cnt);
      chk($sformatf("R4 cmp vec%0d", i), cmp_flag_o, VECS[i].exp_cmp);
      chk($sformatf("R5 wrap vec%0d", i), wrap_flag_o, VECS[i].exp_wrap);
    end

    // R11 register access and read of unused address
    wr(2'd1, 16'h1234);
    rd(2'd1, v); chk("R11 count readback", v, 16'h1234);
    rd(2'd2, v); chk("R11 period readback", v, 16'd3);
    rd(2'd3, v); chk("R11 addr3 zero", v, 0);
    wr(2'd2, 16'd100);
    wr(2'd1, 16'd5);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 16'd7; tick_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
    chk("R11 write beats tick", count_o, 16'd7);

    // R7 stopped mode holds count
    wr(2'd0, cw(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    ticks(5);
    chk("R7 hold", count_o, 16'd7);

    // R6 prescaler ratios
    wr(2'd0, cw(2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    ticks(8);
    chk("R6 div4", count_o, 16'd2);
    wr(2'd0, cw(2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    ticks(7);
    chk("R6 div8 before", count_o, 16'd0);
    ticks(1);
    chk("R6 div8 after", count_o, 16'd1);
    wr(2'd0, cw(2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    ticks(6);
    chk("R6 div2", count_o, 16'd3);

    // R8 clear resets count and prescaler phase
    wr(2'd0, cw(2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(2'd1, 16'd50);
    ticks(3);
    chk("R8 phase pending", count_o, 16'd50);
    wr(2'd0, cw(2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    chk("R8 count zeroed", count_o, 16'd0);
    ticks(1);
    chk("R8 phase reset", count_o, 16'd0);
    ticks(3);
    chk("R8 first step", count_o, 16'd1);
    rd(2'd0, v); chk("R8 clr reads 0", v[4], 0);

    // R10 and R9: interrupt request and flag semantics
    wr(2'd0, cw(2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
    wr(2'd2, 16'd2);
    wr(2'd1, 16'd1);
    ticks(1);
    chk("R10 cmp irq", {cmp_flag_o, irq_o}, 2'b11);
    wr(2'd0, cw(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    chk("R10 cmp masked", {cmp_flag_o, irq_o}, 2'b10);
    ticks(1);
    chk("R10 wrap masked", {wrap_flag_o, irq_o}, 2'b10);
    wr(2'd0, cw(2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1));
    chk("R10 wrap irq", irq_o, 1);
    wr(2'd0, cw(2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0));
    chk("R9 wrap cleared", {cmp_flag_o, wrap_flag_o, irq_o}, 3'b100);
    wr(2'd0, cw(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(2'd0, cw(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    chk("R9 write one no set", {cmp_flag_o, wrap_flag_o}, 2'b00);
    wr(2'd1, 16'd1);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 2'd0;
    wr_data_i = cw(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    tick_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
    chk("R9 event beats clear", cmp_flag_o, 1);
    chk("R9 event count", count_o, 16'd2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule